// File: doc/BRIEF.md
# Programmable Parallel Port Register Core

This block is the host-facing register file of a 24-line parallel port. A host reaches it with an active-low chip select, active-low read and write strobes and a 2-bit address. It writes over an 8-bit input bus and reads back over an 8-bit output bus. Three addresses reach the data latches of ports A, B and C. The fourth address reaches a control register.

A write to the control address carries one of two commands, and bit 7 picks which. With bit 7 set, the byte programs the direction of four port groups and reports the two group modes. With bit 7 clear, it sets or clears one chosen bit of port C, and the other seven bits keep their values. In basic mode the core drives a per-line output enable and an output latch for each line. On a read it returns the live pin value for input lines and the latch value for output lines. The handshake modes appear only as decoded mode fields. Pad cells and strobe handshaking live outside the core.

Top module: `ppio_core`

## Requirements
- R1: A write (cs_n=0, wr_n=0 at a rising clock edge) to address 0, 1 or 2 loads port A, B or C respectively. The value is visible on pa_out, pb_out or pc_out after that edge.
- R2: While cs_n is high, writes change nothing, rdata_oe is 0 and rdata is 0x00.
- R3: A control write (address 3) with bit 7 = 1 programs the port groups. grp_a_mode takes the value 0, 1 or 2 from bits 6:5, coded 00, 01 and 1x. grp_b_mode is bit 2. The direction bits are 4 for port A, 3 for the port C upper nibble, 1 for port B and 0 for the port C lower nibble, and 1 means input. Each output-enable line is the inverse of its direction bit.
- R4: A control write with bit 7 = 0 takes a port C bit index from bits 3:1 and writes bit 0 into that bit of the port C latch. All other port C bits and the whole control state stay unchanged.
- R5: While rst is high, every port is an input (all enables 0), both group modes are 0 and all output latches are 0.
- R6: A read at address 3 returns 0x00 and never exposes the control state.
- R7: While cs_n=0 and rd_n=0, rdata_oe is 1. A read of ports A or B returns the pin inputs without delay when the port is an input, and returns the latch when the port is an output.
- R8: The two port C nibbles have independent directions. A port C read combines pin bits for the input nibble with latch bits for the output nibble.
- R9: A mode-set write clears the output latches of all three ports to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not reading |
| rdata_oe | output | 1 | Host bus drive enable |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |
| grp_a_mode | output | 2 | Group A mode code (0, 1, 2) |
| grp_b_mode | output | 1 | Group B mode code (0, 1) |

## Verification
The assertions check on every cycle that:
- a deselected core drives nothing and the control address reads as zero;
- reset restores all-input directions;
- a bit command leaves the control state and the unselected port C bits untouched;
- a mode set is followed by cleared latches.

Only the bench scenarios can show the rest:
- that each mode-set bit reaches the right group;
- that the address map reaches the right latch;
- that reads mix pin and latch values correctly across the two port C nibbles.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

  typedef enum logic [1:0] {
    GA_BASIC    = 2'd0,
    GA_STROBED  = 2'd1,
    GA_BIDIR    = 2'd2
  } ga_mode_e;

  typedef struct packed {
    ga_mode_e ga_mode;
    logic     a_in;
    logic     cu_in;
    logic     gb_mode;
    logic     b_in;
    logic     cl_in;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{ga_mode: GA_BASIC, a_in: 1'b1, cu_in: 1'b1,
                                   gb_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  localparam logic [1:0] ADDR_A   = 2'd0;
  localparam logic [1:0] ADDR_B   = 2'd1;
  localparam logic [1:0] ADDR_C   = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;

  // Decode a mode-set byte into the stored control fields.
  function automatic ctrl_t decode_mode(input logic [7:0] w);
    ctrl_t c;
    c.ga_mode = w[6] ? GA_BIDIR : (w[5] ? GA_STROBED : GA_BASIC);
    c.a_in    = w[4];
    c.cu_in   = w[3];
    c.gb_mode = w[2];
    c.b_in    = w[1];
    c.cl_in   = w[0];
    return c;
  endfunction

  // Per-bit choice between live pins (input) and latch (output).
  function automatic logic [7:0] merge_read(input logic [7:0] is_in,
                                            input logic [7:0] pins,
                                            input logic [7:0] latch);
    return (is_in & pins) | (~is_in & latch);
  endfunction

endpackage

// File: rtl/ppio_bus_if.sv
module ppio_bus_if #(
  parameter int ADDR_W = 2
) (
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_a,
  output logic              wr_b,
  output logic              wr_c,
  output logic              wr_ctl,
  output logic              rd_en
);
  import ppio_pkg::*;

  logic wr_en;
  assign wr_en  = !cs_n && !wr_n;
  assign rd_en  = !cs_n && !rd_n;
  assign wr_a   = wr_en && (addr == ADDR_A);
  assign wr_b   = wr_en && (addr == ADDR_B);
  assign wr_c   = wr_en && (addr == ADDR_C);
  assign wr_ctl = wr_en && (addr == ADDR_CTL);
endmodule

// File: rtl/ppio_ctrl_reg.sv
module ppio_ctrl_reg #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_ctl,
  input  logic [DATA_W-1:0]  wdata,
  output ppio_pkg::ctrl_t    ctrl,
  output logic               mode_set,
  output logic               bit_cmd,
  output logic [IDX_W-1:0]   bit_idx,
  output logic               bit_val
);
  import ppio_pkg::*;

  assign mode_set = wr_ctl &&  wdata[DATA_W-1];
  assign bit_cmd  = wr_ctl && !wdata[DATA_W-1];
  assign bit_idx  = wdata[IDX_W:1];
  assign bit_val  = wdata[0];

  always_ff @(posedge clk) begin
    if (rst)           ctrl <= CTRL_RESET;
    else if (mode_set) ctrl <= decode_mode(wdata[7:0]);
  end

  // R5: after any reset cycle every group is an input in mode 0
  a_r5_reset_inputs: assert property (@(posedge clk)
    rst |=> (ctrl == CTRL_RESET));

  // R4: a bit command never alters the control state
  a_r4_bit_cmd_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    bit_cmd |=> (ctrl == $past(ctrl)));
endmodule

// File: rtl/ppio_port_latch.sv
module ppio_port_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (ld)    q <= (q & ~mask) | (val & mask);
  end

  // R4: bits outside the write mask hold their value
  a_r4_unmasked_bits_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && ld) |=> (((q ^ $past(q)) & ~$past(mask)) == '0));

  // R2: without a load the latch keeps its value
  a_r2_idle_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld) |=> (q == $past(q)));
endmodule

// File: rtl/ppio_core.sv
module ppio_core #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_oe,
  output logic [1:0]        grp_a_mode,
  output logic              grp_b_mode
);
  import ppio_pkg::*;

  logic wr_a, wr_b, wr_c, wr_ctl, rd_en;
  logic mode_set, bit_cmd, bit_val;
  logic [IDX_W-1:0] bit_idx;
  ctrl_t ctrl;

  ppio_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_ctl(wr_ctl), .rd_en(rd_en)
  );

  ppio_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(wdata),
    .ctrl(ctrl), .mode_set(mode_set), .bit_cmd(bit_cmd),
    .bit_idx(bit_idx), .bit_val(bit_val)
  );

  // Direction vectors, 1 = input, per line
  logic [DATA_W-1:0] a_is_in, b_is_in, c_is_in;
  assign a_is_in = {DATA_W{ctrl.a_in}};
  assign b_is_in = {DATA_W{ctrl.b_in}};
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_cdir
      if (i >= NIB_W) begin : g_up
        assign c_is_in[i] = ctrl.cu_in;
      end else begin : g_lo
        assign c_is_in[i] = ctrl.cl_in;
      end
    end
  endgenerate

  // Port C load: full byte write or single-bit command
  logic [DATA_W-1:0] c_mask, c_val, bit_onehot;
  assign bit_onehot = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
  assign c_mask     = wr_c ? {DATA_W{1'b1}} : bit_onehot;
  assign c_val      = wr_c ? wdata : {DATA_W{bit_val}};

  ppio_port_latch #(.W(DATA_W)) u_pa (
    .clk(clk), .rst(rst), .clr(mode_set), .ld(wr_a),
    .mask({DATA_W{1'b1}}), .val(wdata), .q(pa_out)
  );
  ppio_port_latch #(.W(DATA_W)) u_pb (
    .clk(clk), .rst(rst), .clr(mode_set), .ld(wr_b),
    .mask({DATA_W{1'b1}}), .val(wdata), .q(pb_out)
  );
  ppio_port_latch #(.W(DATA_W)) u_pc (
    .clk(clk), .rst(rst), .clr(mode_set), .ld(wr_c || bit_cmd),
    .mask(c_mask), .val(c_val), .q(pc_out)
  );

  assign pa_oe      = ~a_is_in;
  assign pb_oe      = ~b_is_in;
  assign pc_oe      = ~c_is_in;
  assign grp_a_mode = ctrl.ga_mode;
  assign grp_b_mode = ctrl.gb_mode;

  // Host read path
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_A:  rdata = merge_read(a_is_in, pa_in, pa_out);
        ADDR_B:  rdata = merge_read(b_is_in, pb_in, pb_out);
        ADDR_C:  rdata = merge_read(c_is_in, pc_in, pc_out);
        default: rdata = '0;
      endcase
    end
  end
  assign rdata_oe = rd_en;

  // R2: deselected core never drives the host bus
  a_r2_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!rdata_oe && rdata == '0));

  // R6: control address reads as zero
  a_r6_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rdata_oe && addr == ADDR_CTL) |-> (rdata == '0));

  // R9: a mode set leaves every latch cleared
  a_r9_mode_set_clears: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));
endmodule

// File: tb/ppio_core_tb_top.sv
module ppio_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic rdata_oe, grp_b_mode;
  logic [1:0] grp_a_mode;

  always #5 clk = ~clk;

  ppio_core dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  typedef enum int {S_RDATA, S_RDOE, S_PAO, S_PBO, S_PCO,
                    S_PAE, S_PBE, S_PCE, S_GAM, S_GBM} sel_e;
  typedef struct { sel_e sel; logic [7:0] exp; string req; } item_t;

  item_t sb_q[$];
  event  mon_ev;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  function automatic logic [7:0] observe(sel_e s);
    case (s)
      S_RDATA: return rdata;
      S_RDOE:  return {7'd0, rdata_oe};
      S_PAO:   return pa_out;
      S_PBO:   return pb_out;
      S_PCO:   return pc_out;
      S_PAE:   return pa_oe;
      S_PBE:   return pb_oe;
      S_PCE:   return pc_oe;
      S_GAM:   return {6'd0, grp_a_mode};
      default: return {7'd0, grp_b_mode};
    endcase
  endfunction

  // Monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = observe(it.sel);
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=0x%02h expected=0x%02h",
                   it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(sel_e s, logic [7:0] e, string req);
    item_t it;
    it.sel = s; it.exp = e; it.req = req;
    sb_q.push_back(it);
    ->mon_ev;
    #1;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d, logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk);
    #1;
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(logic [1:0] a, logic [7:0] e, string req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #2;
    expect_val(S_RDOE, 8'h01, req);
    expect_val(S_RDATA, e, req);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5: reset state
    expect_val(S_PAE, 8'h00, "R5");
    expect_val(S_PBE, 8'h00, "R5");
    expect_val(S_PCE, 8'h00, "R5");
    expect_val(S_GAM, 8'h00, "R5");
    expect_val(S_GBM, 8'h00, "R5");
    expect_val(S_PCO, 8'h00, "R5");
    rst = 1'b0;
    pa_in = 8'h5A;
    bus_read(2'd0, 8'h5A, "R7 input pins");
    pa_in = 8'h96;
    bus_read(2'd0, 8'h96, "R7 input pins follow");

    // R3: all output, mode 0
    bus_write(2'd3, 8'h80);
    expect_val(S_PAE, 8'hFF, "R3");
    expect_val(S_PBE, 8'hFF, "R3");
    expect_val(S_PCE, 8'hFF, "R3");
    bus_write(2'd0, 8'h3C);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h81);
    expect_val(S_PAO, 8'h3C, "R1");
    expect_val(S_PBO, 8'hC3, "R1");
    expect_val(S_PCO, 8'h81, "R1");
    bus_read(2'd0, 8'h3C, "R7 output latch");
    pb_in = 8'h00;
    bus_read(2'd1, 8'hC3, "R7 output latch");

    // R2: deselected write and read
    bus_write(2'd0, 8'hFF, 1'b1);
    expect_val(S_PAO, 8'h3C, "R2 write ignored");
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 2'd0;
    #2;
    expect_val(S_RDOE, 8'h00, "R2 no drive");
    expect_val(S_RDATA, 8'h00, "R2 no data");
    rd_n = 1'b1;

    // R6: control address reads zero
    bus_read(2'd3, 8'h00, "R6");

    // R4: single-bit commands
    bus_write(2'd3, 8'h0D);   // index 6, set
    expect_val(S_PCO, 8'hC1, "R4 set bit 6");
    bus_write(2'd3, 8'h00);   // index 0, clear
    expect_val(S_PCO, 8'hC0, "R4 clear bit 0");
    bus_write(2'd3, 8'h0E);   // index 7, clear
    expect_val(S_PCO, 8'h40, "R4 clear bit 7");
    expect_val(S_PCE, 8'hFF, "R4 ctrl unchanged");
    expect_val(S_PAO, 8'h3C, "R4 port A unchanged");

    // R9 / R3 / R8: mode set with A and C upper input
    bus_write(2'd3, 8'h98);
    expect_val(S_PAO, 8'h00, "R9");
    expect_val(S_PBO, 8'h00, "R9");
    expect_val(S_PCO, 8'h00, "R9");
    expect_val(S_PAE, 8'h00, "R3 A input");
    expect_val(S_PBE, 8'hFF, "R3 B output");
    expect_val(S_PCE, 8'h0F, "R8 nibble dirs");
    pc_in = 8'hA5;
    bus_write(2'd2, 8'h3C);
    bus_read(2'd2, 8'hAC, "R8 mixed read");

    // R3: mode fields
    bus_write(2'd3, 8'hE5);
    expect_val(S_GAM, 8'h02, "R3 mode 1x");
    expect_val(S_GBM, 8'h01, "R3 group B mode");
    expect_val(S_PCE, 8'hF0, "R8 lower input");
    expect_val(S_PBE, 8'hFF, "R3 B output");
    bus_read(2'd2, 8'h05, "R8 mixed read lower");
    bus_write(2'd3, 8'hA3);
    expect_val(S_GAM, 8'h01, "R3 mode 01");
    expect_val(S_GBM, 8'h00, "R3 group B mode 0");
    expect_val(S_PBE, 8'h00, "R3 B input");
    bus_write(2'd3, 8'hC0);
    expect_val(S_GAM, 8'h02, "R3 mode 10");

    // R5: reset in mid-run
    bus_write(2'd1, 8'h77);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_val(S_PBE, 8'h00, "R5 mid-run");
    expect_val(S_PBO, 8'h00, "R5 mid-run");
    expect_val(S_GAM, 8'h00, "R5 mid-run");
    rst = 1'b0;

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule